// File: doc/BRIEF.md
# Two-Port Latched Pin-Sense Event Detector

This block watches two input ports of up to 32 pins each and folds all of them into one event flag and one interrupt request. Each pin is given a sense setting: off, trigger on high, or trigger on low. Incoming levels first pass through a synchronizer. A pin whose synchronized level matches its enabled sense sets a sticky bit in its port's latch. Software clears latch bits by writing ones.

Each port produces its own detect signal. In direct mode that signal comes from the pins that currently match. In latched mode it comes from the port's latch bits. The two detect signals are ORed together. A low-to-high transition of the combined signal sets the event flag.

A shared event is hard to re-arm when software clears latch bits but some remain set. In that case the combined detect would stay high and no new edge would appear. To handle this, a clear on a latched port that leaves bits set in that port holds the combined detect low for a fixed blanking window. When the window ends, a new edge is produced. A clear that empties the cleared port produces no re-arm. All configuration goes through a single-cycle register-write port.

Top module: `pin_sense_evt`

## Requirements
- R1: Each pin has an enable bit and a polarity bit (1 = sense high, 0 = sense low). With enable at 0 the pin never sets its latch bit. With enable at 1 the latch bit sets once the pin level equals the polarity. The pin level reaches the latch on the third rising clock edge after it is applied.
- R2: A latch bit stays set after its pin stops matching, until software clears it.
- R3: Writing to a port's latch-clear register clears exactly the latch bits written as 1 and leaves the other bits unchanged.
- R4: If a pin still matches in the cycle its clear is written, its latch bit stays set.
- R5: In direct mode (mode bit 0 = 0), each new rise of a matching pin sets the event flag.
- R6: In latched mode (mode bit 0 = 1), the first latch bit to set raises the event flag. Further pin activity while that port's latch is nonzero raises no new event.
- R7: The per-port detects are ORed. Activity on a second port while the combined detect is already high raises no event.
- R8: Writing 0 to bit 0 of the event register clears the flag. While the combined detect stays high, this does not by itself set the flag again.
- R9: A latch clear on a latched port that leaves any of that port's bits set holds the combined detect low for BLANK cycles (16 by default). The event flag then sets on the 17th clock edge after the clear write.
- R10: A latch clear that leaves the cleared port all zero, while the other port still holds set bits, raises no new event.
- R11: The interrupt output is high exactly when the event flag and the interrupt-enable bit (bit 0 of the enable register) are both 1.
- R12: Reset clears all latches, the event flag, the interrupt output, the interrupt enable, all configuration and the blanking counter.

Register map: port p uses word addresses 4p (enable), 4p+1 (polarity), 4p+2 (mode), 4p+3 (latch clear). Address 8 is the event register and address 9 is the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | PORTS*PINS | Asynchronous pin levels, port p at bits p*PINS upward |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address |
| wr_data | input | PINS | Register write data |
| latch_o | output | PORTS*PINS | Latch contents of all ports |
| event_o | output | 1 | Port event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle:
- Latch bits never drop unless they are cleared.
- A matching pin always wins over its own clear.
- The interrupt output always equals the event flag gated by the enable.
- No event rises while the blanking counter is running, and the counter never exceeds its limit.

Other behaviour only the bench scenarios can show:
- The three-edge synchronizer latency.
- The event being suppressed when a second port becomes active.
- Re-arming on the exact 17th edge after a partial clear.
- No re-arm when the cleared port becomes empty.

// File: rtl/pse_pkg.sv
package pse_pkg;
  localparam int unsigned PORT_STRIDE   = 4;
  localparam int unsigned OFS_SENSE_EN  = 0;
  localparam int unsigned OFS_SENSE_POL = 1;
  localparam int unsigned OFS_MODE      = 2;
  localparam int unsigned OFS_LATCH_CLR = 3;

  typedef enum logic {
    DET_DIRECT  = 1'b0,
    DET_LATCHED = 1'b1
  } det_mode_e;
endpackage

// File: rtl/pse_sync.sv
module pse_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pse_port.sv
module pse_port
  import pse_pkg::*;
#(
  parameter int PINS     = 32,
  parameter int AW       = 4,
  parameter int PORT_IDX = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_s,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [PINS-1:0] wr_data,
  output logic [PINS-1:0] latch_o,
  output logic [PINS-1:0] match_o,
  output logic [PINS-1:0] clr_o,
  output logic            detect_o,
  output logic            rearm_o
);
  localparam int unsigned BASE = PORT_IDX * PORT_STRIDE;
  localparam logic [AW-1:0] A_EN  = AW'(BASE + OFS_SENSE_EN);
  localparam logic [AW-1:0] A_POL = AW'(BASE + OFS_SENSE_POL);
  localparam logic [AW-1:0] A_MOD = AW'(BASE + OFS_MODE);
  localparam logic [AW-1:0] A_CLR = AW'(BASE + OFS_LATCH_CLR);

  logic [PINS-1:0] en_q, pol_q, latch_q, latch_d;
  det_mode_e       mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= DET_DIRECT;
    end else if (wr_en) begin
      if (wr_addr == A_EN)  en_q   <= wr_data;
      if (wr_addr == A_POL) pol_q  <= wr_data;
      if (wr_addr == A_MOD) mode_q <= det_mode_e'(wr_data[0]);
    end
  end

  // a pin matches when enabled and its level equals the polarity
  assign match_o = en_q & ~(pin_s ^ pol_q);
  assign clr_o   = (wr_en && wr_addr == A_CLR) ? wr_data : '0;
  // a new match outranks a clear of the same bit
  assign latch_d = (latch_q & ~clr_o) | match_o;

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else     latch_q <= latch_d;
  end

  assign latch_o  = latch_q;
  assign detect_o = (mode_q == DET_LATCHED) ? (|latch_q) : (|match_o);
  assign rearm_o  = (mode_q == DET_LATCHED) && (|clr_o) && (|latch_d);
endmodule

// File: rtl/pse_evt.sv
module pse_evt
  import pse_pkg::*;
#(
  parameter int PORTS = 2,
  parameter int BLANK = 16,
  parameter int AW    = 4,
  parameter int CW    = $clog2(BLANK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PORTS-1:0] det_vec,
  input  logic [PORTS-1:0] rearm_vec,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_bit0,
  output logic             event_o,
  output logic             irq_o,
  output logic             ien_o,
  output logic [CW-1:0]    mask_cnt_o
);
  localparam logic [AW-1:0] A_EVT = AW'(PORTS * PORT_STRIDE);
  localparam logic [AW-1:0] A_IEN = AW'(PORTS * PORT_STRIDE + 1);

  logic [CW-1:0] cnt_q;
  logic          prev_q, evt_q, ien_q, irq_q;
  logic          det_gated, rise, evt_clr, evt_d, ien_d;

  // blanking applied after the OR of all ports
  assign det_gated = (|det_vec) && (cnt_q == '0);
  assign rise      = det_gated && !prev_q;
  assign evt_clr   = wr_en && (wr_addr == A_EVT) && !wr_bit0;
  assign evt_d     = rise || (evt_q && !evt_clr);
  assign ien_d     = (wr_en && wr_addr == A_IEN) ? wr_bit0 : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (|rearm_vec)        cnt_q <= CW'(BLANK);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      prev_q <= det_gated;
      evt_q  <= evt_d;
      ien_q  <= ien_d;
      irq_q  <= evt_d && ien_d;
    end
  end

  assign event_o    = evt_q;
  assign irq_o      = irq_q;
  assign ien_o      = ien_q;
  assign mask_cnt_o = cnt_q;
endmodule

// File: rtl/pin_sense_evt.sv
module pin_sense_evt #(
  parameter int PORTS = 2,
  parameter int PINS  = 32,
  parameter int BLANK = 16,
  parameter int SYNC  = 2,
  parameter int AW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PORTS*PINS-1:0] pins_i,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [PINS-1:0]       wr_data,
  output logic [PORTS*PINS-1:0] latch_o,
  output logic                  event_o,
  output logic                  irq_o
);
  localparam int NP = PORTS * PINS;
  localparam int CW = $clog2(BLANK + 1);

  logic [NP-1:0]    pins_s, match_all, clr_all;
  logic [PORTS-1:0] det_vec, rearm_vec;
  logic [CW-1:0]    mask_cnt;
  logic             ien;

  pse_sync #(.W(NP), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .d(pins_i), .q(pins_s)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    pse_port #(.PINS(PINS), .AW(AW), .PORT_IDX(p)) u_port (
      .clk      (clk),
      .rst      (rst),
      .pin_s    (pins_s[p*PINS +: PINS]),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .latch_o  (latch_o[p*PINS +: PINS]),
      .match_o  (match_all[p*PINS +: PINS]),
      .clr_o    (clr_all[p*PINS +: PINS]),
      .detect_o (det_vec[p]),
      .rearm_o  (rearm_vec[p])
    );
  end

  pse_evt #(.PORTS(PORTS), .BLANK(BLANK), .AW(AW), .CW(CW)) u_evt (
    .clk        (clk),
    .rst        (rst),
    .det_vec    (det_vec),
    .rearm_vec  (rearm_vec),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_bit0    (wr_data[0]),
    .event_o    (event_o),
    .irq_o      (irq_o),
    .ien_o      (ien),
    .mask_cnt_o (mask_cnt)
  );
endmodule

// File: rtl/pse_chk.sv
module pse_chk #(
  parameter int NP    = 64,
  parameter int CW    = 5,
  parameter int BLANK = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] latch_o,
  input logic [NP-1:0] match_all,
  input logic [NP-1:0] clr_all,
  input logic          event_o,
  input logic          irq_o,
  input logic          ien,
  input logic [CW-1:0] mask_cnt
);
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_o & $past(match_all)) == $past(match_all)));

  // R2 R3
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_o & $past(latch_o & ~clr_all)) == $past(latch_o & ~clr_all)));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (event_o && ien));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    mask_cnt <= CW'(BLANK));

  // R9
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_cnt != '0) |=> !$rose(event_o));
endmodule

bind pin_sense_evt pse_chk #(.NP(NP), .CW(CW), .BLANK(BLANK)) chk_i (
  .clk(clk), .rst(rst), .latch_o(latch_o), .match_all(match_all),
  .clr_all(clr_all), .event_o(event_o), .irq_o(irq_o), .ien(ien),
  .mask_cnt(mask_cnt)
);

// File: tb/pin_sense_evt_tb_top.sv
module pin_sense_evt_tb_top;
  localparam int PORTS = 2;
  localparam int PINS  = 32;
  localparam int AW    = 4;
  localparam int NP    = PORTS * PINS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins_i = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [PINS-1:0] wr_data = '0;
  logic [NP-1:0] latch_o;
  logic          event_o, irq_o;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pin_sense_evt #(.PORTS(PORTS), .PINS(PINS), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .pins_i(pins_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .latch_o(latch_o),
    .event_o(event_o), .irq_o(irq_o)
  );

  // {enable, polarity, pin level, expected latch bit}
  localparam logic [3:0] SENSE_VEC [6] = '{
    4'b0110, 4'b0000, 4'b1111, 4'b1100, 4'b1001, 4'b1010
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input int addr, input logic [PINS-1:0] data);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = data;
    tick();
    wr_en   = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pins_i = '0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int idx);
    pins_i[idx] = 1'b1;
    tick(2);
    pins_i[idx] = 1'b0;
    tick(4);
  endtask

  initial begin
    // R12: reset state
    do_reset();
    check(latch_o == '0, "R12 latch after reset", latch_o, 0);
    check(event_o == 1'b0, "R12 event after reset", event_o, 0);
    check(irq_o == 1'b0, "R12 irq after reset", irq_o, 0);

    // R1: sense table walk
    for (int v = 0; v < 6; v++) begin
      do_reset();
      pins_i[0] = SENSE_VEC[v][1];
      tick(3);
      wr(1, {31'b0, SENSE_VEC[v][2]});
      wr(0, {31'b0, SENSE_VEC[v][3]});
      tick(4);
      check(latch_o[0] == SENSE_VEC[v][0], "R1 sense vector", latch_o[0], SENSE_VEC[v][0]);
    end

    // R1 latency, R2 sticky
    do_reset();
    wr(1, 32'h7);
    wr(0, 32'h7);
    pins_i[2:0] = 3'b111;
    tick(2);
    check(latch_o[2:0] == 3'b000, "R1 not before third edge", latch_o[2:0], 0);
    tick(1);
    check(latch_o[2:0] == 3'b111, "R1 latched on third edge", latch_o[2:0], 7);
    pins_i[2:0] = 3'b000;
    tick(5);
    check(latch_o[2:0] == 3'b111, "R2 sticky after pin drop", latch_o[2:0], 7);

    // R3: per-bit clear
    wr(3, 32'h5);
    check(latch_o[31:0] == 32'h2, "R3 write-one-to-clear", latch_o[31:0], 2);

    // R4: match wins over clear
    pins_i[1] = 1'b1;
    tick(3);
    wr(3, 32'h2);
    check(latch_o[1] == 1'b1, "R4 set beats clear", latch_o[1], 1);
    pins_i[1] = 1'b0;

    // R5 / R8 / R11: direct mode on port 1 pin 3
    do_reset();
    wr(5, 32'h8);
    wr(4, 32'h8);
    pins_i[35] = 1'b1;
    tick(5);
    check(event_o == 1'b1, "R5 direct event", event_o, 1);
    check(irq_o == 1'b0, "R11 irq masked when disabled", irq_o, 0);
    wr(9, 32'h1);
    check(irq_o == 1'b1, "R11 irq when enabled", irq_o, 1);
    wr(8, 32'h0);
    check(event_o == 1'b0, "R8 event cleared", event_o, 0);
    check(irq_o == 1'b0, "R11 irq follows event", irq_o, 0);
    tick(5);
    check(event_o == 1'b0, "R8 no event while detect high", event_o, 0);
    pins_i[35] = 1'b0;
    tick(5);
    pins_i[35] = 1'b1;
    tick(5);
    check(event_o == 1'b1, "R5 second rise", event_o, 1);

    // R6 / R7 / R10 / R9: latched mode on both ports
    do_reset();
    wr(1, 32'h1); wr(0, 32'h1); wr(2, 32'h1);
    wr(5, 32'h3); wr(4, 32'h3); wr(6, 32'h1);
    pulse(0);
    check(event_o == 1'b1, "R6 first latch raises event", event_o, 1);
    wr(8, 32'h0);
    pulse(0);
    check(event_o == 1'b0, "R6 no event while latch set", event_o, 0);
    pulse(32);
    check(latch_o[32] == 1'b1, "R7 port1 latched", latch_o[32], 1);
    check(event_o == 1'b0, "R7 no event from second port", event_o, 0);
    wr(3, 32'h1);
    check(latch_o[31:0] == '0, "R10 port0 emptied", latch_o[31:0], 0);
    tick(20);
    check(event_o == 1'b0, "R10 no re-arm", event_o, 0);
    pulse(33);
    wr(7, 32'h1);
    check(latch_o[63:32] == 32'h2, "R9 partial clear", latch_o[63:32], 2);
    tick(16);
    check(event_o == 1'b0, "R9 blanked through 16 edges", event_o, 0);
    tick(1);
    check(event_o == 1'b1, "R9 re-arm on 17th edge", event_o, 1);

    // R12: reset mid-operation
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check(latch_o == '0 && event_o == 1'b0 && irq_o == 1'b0,
          "R12 reset clears state", {latch_o[62:0], event_o}, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule